// File: doc/BRIEF.md
# Upsampling Comb Interpolator

This block takes 12-bit audio samples arriving at the low rate of 8 ksps and turns them into a stream at five times that rate, 40 ksps, ready for a pulse-width DAC stage. A rate tick from the surrounding system marks each high-rate output slot. Each accepted input value is held for five consecutive slots (zero-order hold). The slot stream then passes through a recursive moving-average filter of length 10. At every slot this filter adds the newest slot value to an unscaled running sum and removes the value that entered ten slots earlier. The output is that sum divided by ten and clamped to the 12-bit code range. A constant input therefore comes out at the same value once the filter has filled.

Input samples may arrive in any clock cycle. A hold period starts on every fifth tick, counted from reset. At that point the block takes the most recent sample that has arrived since the previous period start. A sample offered in the same cycle as that tick also counts. If no sample has arrived, the previous value is held for another period and an underrun flag accompanies that output slot.

Top module: `ucmb_interp`

## Requirements
- R1: `out_valid` is high in exactly the clock cycle after each cycle in which `tick` is high, and low in every other cycle.
- R2: Hold periods are groups of five consecutive ticks, counted from reset. The value taken at the first tick of a period is the slot value for all five slots of that period.
- R3: On each output slot, `out_data` equals floor(S/10). S is the sum of the ten most recent slot values, with slots before reset counted as zero. Between slots, `out_data` keeps its last value.
- R4: At a period-start tick with no sample received since the previous period start, the previous slot value is repeated. `out_underrun` is high together with that slot's `out_valid`, and low otherwise.
- R5: A sample with `in_valid` high in the same cycle as a period-start tick is the value used for that period.
- R6: When several samples arrive within one period, only the last of them is used at the next period start.
- R7: A sample that arrives after a period-start tick does not change any output slot before the next period-start tick.
- R8: While `rst_n` is low, and after reset until the first tick, `out_valid` and `out_underrun` are 0 and `out_data` is 0.
- R9: A constant input c yields `out_data` = c once ten slots of c have passed, including the full-scale code 4095. Output codes never exceed 4095.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| tick | input | 1 | High for one cycle per high-rate output slot |
| in_valid | input | 1 | Input sample strobe (low-rate stream) |
| in_data | input | 12 | Input sample, unsigned code |
| out_valid | output | 1 | High for one cycle per produced output slot |
| out_data | output | 12 | Filtered high-rate sample, unsigned code |
| out_underrun | output | 1 | High with an output slot whose period repeated the old value |

## Verification
The bench builds the block with its default parameters: 12-bit data, a factor of five and ten taps. With these values the filter window covers exactly two hold periods. Every output therefore mixes at most two or three distinct held values, and step changes settle within two periods where the result is easy to predict. Full-scale input drives the running sum to its largest value, 40950, which checks the accumulator width and the clamp. Ticks two cycles apart leave room for samples in the same cycle as a period start, in the middle of a period and twice within one period, with a reset in the middle of the run.

// File: rtl/ucmb_pkg.sv
package ucmb_pkg;
  // width of an unscaled sum of `terms` values of `dw` bits each
  function automatic int unsigned sum_width(input int unsigned dw,
                                            input int unsigned terms);
    return dw + $clog2(terms);
  endfunction
endpackage

// File: rtl/ucmb_hold.sv
module ucmb_hold #(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned UP_FACTOR = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic [DATA_W-1:0] slot_data_o,
  output logic              slot_under_o
);
  localparam int unsigned PH_W = (UP_FACTOR > 1) ? $clog2(UP_FACTOR) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(UP_FACTOR - 1);

  logic [PH_W-1:0]   phase_q, phase_d;
  logic              pend_v_q, pend_v_d;
  logic [DATA_W-1:0] pend_q, pend_d;
  logic [DATA_W-1:0] held_q, held_d;
  logic              period_start, fresh_v;
  logic [DATA_W-1:0] fresh;

  always_comb begin
    period_start = tick_i && (phase_q == '0);
    // a same-cycle sample is newer than any pending one
    fresh_v      = in_valid_i || pend_v_q;
    fresh        = in_valid_i ? in_data_i : pend_q;
    slot_data_o  = (period_start && fresh_v) ? fresh : held_q;
    slot_under_o = period_start && !fresh_v;
    held_d       = period_start ? slot_data_o : held_q;

    pend_v_d = pend_v_q;
    pend_d   = pend_q;
    if (period_start) begin
      pend_v_d = 1'b0;
    end else if (in_valid_i) begin
      pend_v_d = 1'b1;
      pend_d   = in_data_i;
    end

    phase_d = phase_q;
    if (tick_i) phase_d = (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      pend_v_q <= 1'b0;
      pend_q   <= '0;
      held_q   <= '0;
    end else begin
      phase_q  <= phase_d;
      pend_v_q <= pend_v_d;
      if (in_valid_i) pend_q <= pend_d;
      if (period_start) held_q <= held_d;
    end
  end

  // R2: held value only changes at a period start
  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && phase_q != '0) |=> (held_q == $past(held_q)));
  // R2: phase counter stays inside the period
  p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q <= PH_LAST));
endmodule

// File: rtl/ucmb_comb.sv
module ucmb_comb #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned TAPS   = 10,
  parameter int unsigned ACC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] x_i,
  output logic [ACC_W-1:0]  acc_next_o
);
  localparam int unsigned EXT_W = ACC_W - DATA_W;
  localparam logic [ACC_W-1:0] ACC_MAX = ACC_W'(TAPS * ((1 << DATA_W) - 1));

  logic [ACC_W-1:0] acc_q;
  logic [DATA_W-1:0] oldest;

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] d;
    if (i == 0) begin : g_head
      always_comb d = x_i;
    end else begin : g_body
      always_comb d = g_tap[i-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (tick_i) q <= d;
    end
  end

  always_comb begin
    oldest     = g_tap[TAPS-1].q;
    acc_next_o = acc_q + {{EXT_W{1'b0}}, x_i} - {{EXT_W{1'b0}}, oldest};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (tick_i) acc_q <= acc_next_o;
  end

  // R3: the running sum never leaves the range of TAPS full-scale terms
  p_acc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q <= ACC_MAX));
  // R3: the newest slot value enters the window on each slot
  p_window_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (g_tap[0].q == $past(x_i)));
endmodule

// File: rtl/ucmb_scale.sv
module ucmb_scale #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned TAPS   = 10,
  parameter int unsigned ACC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              under_i,
  input  logic [ACC_W-1:0]  acc_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_under_o
);
  localparam logic [ACC_W-1:0] CODE_MAX = ACC_W'((1 << DATA_W) - 1);

  logic [ACC_W-1:0]  quot;
  logic [DATA_W-1:0] data_d;
  logic              valid_d, under_d;

  always_comb begin
    quot    = acc_i / ACC_W'(TAPS);
    data_d  = (quot > CODE_MAX) ? CODE_MAX[DATA_W-1:0] : quot[DATA_W-1:0];
    valid_d = tick_i;
    under_d = tick_i && under_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_under_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= valid_d;
      out_under_o <= under_d;
      if (tick_i) out_data_o <= data_d;
    end
  end

  // R1: one output slot per tick, one cycle later
  p_valid_after_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> out_valid_o);
  p_no_spurious_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> !out_valid_o);
  // R4: underrun only marks a real output slot
  p_under_with_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_under_o |-> out_valid_o);
  // R3: data holds between slots
  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(out_data_o));
endmodule

// File: rtl/ucmb_interp.sv
module ucmb_interp #(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned UP_FACTOR = 5,
  parameter int unsigned TAPS      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_underrun
);
  localparam int unsigned ACC_W = ucmb_pkg::sum_width(DATA_W, TAPS);

  logic [DATA_W-1:0] slot_data;
  logic              slot_under;
  logic [ACC_W-1:0]  acc_next;

  ucmb_hold #(.DATA_W(DATA_W), .UP_FACTOR(UP_FACTOR)) u_hold (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .in_valid_i(in_valid), .in_data_i(in_data),
    .slot_data_o(slot_data), .slot_under_o(slot_under)
  );

  ucmb_comb #(.DATA_W(DATA_W), .TAPS(TAPS), .ACC_W(ACC_W)) u_comb (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .x_i(slot_data), .acc_next_o(acc_next)
  );

  ucmb_scale #(.DATA_W(DATA_W), .TAPS(TAPS), .ACC_W(ACC_W)) u_scale (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .under_i(slot_under),
    .acc_i(acc_next), .out_valid_o(out_valid),
    .out_data_o(out_data), .out_under_o(out_underrun)
  );
endmodule

// File: tb/ucmb_interp_bench.sv
module ucmb_interp_bench;
  localparam int DW = 12, UPF = 5, NT = 10, MAXV = 4095;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, out_underrun;
  logic [DW-1:0] out_data;

  int checks = 0, failures = 0;
  string cur_req = "R8";

  int m_phase, m_pd, m_held;
  bit m_pv;
  int hist[$];
  bit exp_valid, exp_under;
  int exp_data;

  always #10 clk = ~clk;

  ucmb_interp #(.DATA_W(DW), .UP_FACTOR(UPF), .TAPS(NT)) u_ucmb_interp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_underrun(out_underrun)
  );

  task automatic check(input string req, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, expv, $time);
    end
  endtask

  // behavioural reference: window kept as a queue, sum recomputed each slot
  task automatic model_step(input bit r, input bit t, input bit v, input int d);
    int x, s;
    if (!r) begin
      m_phase = 0; m_pv = 0; m_pd = 0; m_held = 0;
      hist.delete();
      for (int i = 0; i < NT; i++) hist.push_back(0);
      exp_valid = 0; exp_under = 0; exp_data = 0;
      return;
    end
    exp_valid = t;
    exp_under = 0;
    if (t && m_phase == 0) begin
      if (v) x = d;
      else if (m_pv) x = m_pd;
      else begin x = m_held; exp_under = 1; end
      m_held = x; m_pv = 0;
    end else begin
      x = m_held;
      if (v) begin m_pv = 1; m_pd = d; end
    end
    if (t) begin
      hist.push_back(x);
      void'(hist.pop_front());
      s = 0;
      foreach (hist[i]) s += hist[i];
      exp_data = (s / NT > MAXV) ? MAXV : s / NT;
      m_phase = (m_phase + 1) % UPF;
    end
  endtask

  // compare outputs from the last edge, then drive the next inputs
  task automatic step(input bit r, input bit t, input bit v, input int d);
    @(negedge clk);
    check("R1", out_valid, exp_valid, {cur_req, " out_valid"});
    check("R4", out_underrun, exp_under, {cur_req, " out_underrun"});
    check("R3", out_data, exp_data, {cur_req, " out_data"});
    rst_n = r; tick = t; in_valid = v; in_data = DW'(d);
    model_step(r, t, v, d);
  endtask

  // one hold period: ticks every other cycle; optional samples at given cycles
  task automatic period(input int c1, input int v1, input int c2, input int v2);
    for (int c = 0; c < 2 * UPF; c++) begin
      bit g;
      int dv;
      g = (c == c1) || (c == c2);
      dv = (c == c2) ? v2 : v1;
      step(1'b1, (c % 2) == 0, g, g ? dv : 0);
    end
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_step(0, 0, 0, 0);
    // R8: reset state
    cur_req = "R8";
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, 77);
    step(1'b1, 1'b0, 1'b0, 0);
    step(1'b1, 1'b0, 1'b0, 0);
    // R4: first period with nothing received
    cur_req = "R4";
    period(-1, 0, -1, 0);
    // R2/R7: samples mid-period, used from the next period on
    cur_req = "R7";
    period(3, 1200, -1, 0);
    cur_req = "R2";
    period(5, 300, -1, 0);
    period(1, 2500, -1, 0);
    // R5: sample in the same cycle as the period-start tick
    cur_req = "R5";
    period(0, 900, -1, 0);
    period(0, 3100, -1, 0);
    // R6: two samples in one period, last one wins
    cur_req = "R6";
    period(2, 111, 7, 2222);
    period(-1, 0, -1, 0);
    // R4: missing sample repeats the old value
    cur_req = "R4";
    period(-1, 0, -1, 0);
    // R9: full scale and mid-scale DC
    cur_req = "R9";
    for (int i = 0; i < 3; i++) period(0, MAXV, -1, 0);
    step(1'b1, 1'b0, 1'b0, 0);
    check("R9", out_data, MAXV, "full-scale dc");
    for (int i = 0; i < 3; i++) period(4, 1000, -1, 0);
    step(1'b1, 1'b0, 1'b0, 0);
    check("R9", out_data, 1000, "mid-scale dc");
    // R8: reset in mid-run clears everything
    cur_req = "R8";
    step(1'b0, 1'b0, 1'b0, 0);
    step(1'b1, 1'b0, 1'b0, 0);
    step(1'b1, 1'b0, 1'b0, 0);
    check("R8", out_data, 0, "data after reset");
    cur_req = "R3";
    period(0, 50, -1, 0);
    period(6, 4000, -1, 0);
    period(-1, 0, -1, 0);
    period(-1, 0, -1, 0);
    step(1'b1, 1'b0, 1'b0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule